// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the 13-bit fetch address of a small 8-bit controller core that uses 14-bit instruction words. Software cannot reach the upper five counter bits directly. Instead, a separate 5-bit page latch is written like any data register, and its contents reach the counter's upper bits at two moments.

The first moment is when an instruction writes the counter's low byte. All five latch bits are then copied in. The second is when a jump or call loads the counter. Only the two top latch bits are used there, because the 11-bit opcode immediate already fills the lower bits.

The counter can also step forward by one on a normal fetch, or be reloaded from the return stack. Loading from the return stack leaves the latch alone. The counter's current value is presented as the next fetch address, and its low byte can be read back as a data register.

A computed jump is an ALU sum written into the low byte. The block never carries that sum into the page bits. A table that crosses a 256-word boundary therefore lands in the page held by the latch, not in the following page.

Top module: `pcu_paged_pc`

## Requirements
- R1: A synchronous active-low reset clears the counter to 0x0000 and the page latch to 0x00, whatever else is asserted.
- R2: With only `step_en` asserted, the counter rises by one through all 13 bits: 0x00FF goes to 0x0100, and 0x1FFF wraps to 0x0000.
- R3: A low-byte write makes the counter equal to {latch[4:0], data[7:0]}. No carry from the old low byte or from the data reaches bits 12:8.
- R4: A jump or call makes the counter equal to {latch[4:3], imm[10:0]}.
- R5: A return-stack load copies all 13 bits of `ret_addr` into the counter and leaves the page latch unchanged.
- R6: A latch write stores the 5-bit value. `latch_rd` returns the stored latch value, even when it differs from the counter's upper bits.
- R7: `lo_rd` always equals counter bits 7:0, and `fetch_addr` is the full counter.
- R8: The sources take effect in a fixed priority: return load first, then jump, then low-byte write, then step. With no source asserted, the counter holds its value.
- R9: When a latch write and a low-byte write happen in the same cycle, the counter takes the latch value held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Sequential fetch step |
| lo_wr_en | input | 1 | Write the counter low byte |
| lo_wr_data | input | 8 | ALU result for the low byte |
| latch_wr_en | input | 1 | Write the page latch |
| latch_wr_data | input | 5 | New page latch value |
| jmp_en | input | 1 | Jump or call load |
| jmp_imm | input | 11 | Opcode immediate |
| ret_en | input | 1 | Load from the return stack |
| ret_addr | input | 13 | Address popped from the return stack |
| fetch_addr | output | 13 | Next fetch address (the counter) |
| lo_rd | output | 8 | Readback of the counter low byte |
| latch_rd | output | 5 | Readback of the page latch |

## Verification
The bench writes 0xFF and then 0x05 into the low byte while the latch is unchanged.
- A design that added a carry would land one page too high.
- A design that kept the old page would miss a latch update.

Jumps are driven with latch values whose top two bits differ from the lower three. A design that took the wrong latch slice, or the counter's own upper bits, would produce a visibly wrong page.

Other corner cases are also covered:
- the step across 0x1FFF to 0x0000 and across a page boundary;
- all sources asserted at once, where a wrong priority shows up as the wrong address;
- a latch write in the same cycle as a low-byte write, which shows whether old or new latch bits are used;
- a reset taken mid-run with other loads asserted.

// File: rtl/pcu_pkg.sv
// Package: shared types of the paged program counter unit.
// Assumes: one load source is chosen per cycle.
package pcu_pkg;

    // Which value the counter takes at the next edge.
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_STEP = 3'd1,
        SRC_LOW  = 3'd2,
        SRC_JUMP = 3'd3,
        SRC_RET  = 3'd4
    } pc_src_e;

endpackage

// File: rtl/pcu_select.sv
// Module: pcu_select
// Turns the four load requests into one source code.
// Fixed priority: return, then jump, then low-byte write, then step.
// Assumes: the requests are already qualified by the decoder.
module pcu_select
    import pcu_pkg::*;
(
    input  logic    ret_en,
    input  logic    jmp_en,
    input  logic    lo_wr_en,
    input  logic    step_en,
    output pc_src_e src
);

    // Priority encode the requests.
    always_comb begin
        if (ret_en)        src = SRC_RET;
        else if (jmp_en)   src = SRC_JUMP;
        else if (lo_wr_en) src = SRC_LOW;
        else if (step_en)  src = SRC_STEP;
        else               src = SRC_HOLD;
    end

endmodule

// File: rtl/pcu_latch.sv
// Module: pcu_latch
// Page latch register: written as a data register, read back unchanged.
// Assumes: synchronous active-low reset.
module pcu_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);

    // Store a new page value on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end

    // R5/R6: without a write the latch keeps its value (a return load included).
    p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> q == $past(q));

    // R6: a write is visible on the next cycle.
    p_latch_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> q == $past(wr_data));

endmodule

// File: rtl/pcu_next.sv
// Module: pcu_next
// Forms the next counter value for the selected source.
// The low-byte path takes every latch bit. The jump path takes only
// the latch bits above the immediate. No carry crosses from the low
// byte into the page.
// Assumes: PC_W - JMP_W <= PC_W - LO_W.
module pcu_next
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int JMP_W = 11,
    localparam int LATCH_W = PC_W - LO_W
) (
    input  pc_src_e            src,
    input  logic [PC_W-1:0]    pc_q,
    input  logic [LATCH_W-1:0] latch_q,
    input  logic [LO_W-1:0]    lo_data,
    input  logic [JMP_W-1:0]   jmp_imm,
    input  logic [PC_W-1:0]    ret_addr,
    output logic [PC_W-1:0]    pc_d
);

    localparam int HI_J_W = PC_W - JMP_W;

    logic [PC_W-1:0] jmp_target;
    logic [PC_W-1:0] low_target;

    // Jump target: the top latch bits above the immediate, when any exist.
    generate
        if (HI_J_W > 0) begin : g_paged_jump
            assign jmp_target = {latch_q[LATCH_W-1 -: HI_J_W], jmp_imm};
        end else begin : g_flat_jump
            assign jmp_target = jmp_imm[PC_W-1:0];
        end
    endgenerate

    // Low-byte target: the whole latch above the written byte.
    assign low_target = {latch_q, lo_data};

    // Choose the next counter value.
    always_comb begin
        case (src)
            SRC_RET:  pc_d = ret_addr;
            SRC_JUMP: pc_d = jmp_target;
            SRC_LOW:  pc_d = low_target;
            SRC_STEP: pc_d = pc_q + PC_W'(1);
            default:  pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pcu_paged_pc.sv
// Module: pcu_paged_pc (top)
// 13-bit program counter with a readable low byte. The upper bits are
// fed only from a page latch.
// Assumes: synchronous active-low reset.
// Assumes: the caller asserts at most the loads it means.
module pcu_paged_pc
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int JMP_W = 11,
    localparam int LATCH_W = PC_W - LO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               lo_wr_en,
    input  logic [LO_W-1:0]    lo_wr_data,
    input  logic               latch_wr_en,
    input  logic [LATCH_W-1:0] latch_wr_data,
    input  logic               jmp_en,
    input  logic [JMP_W-1:0]   jmp_imm,
    input  logic               ret_en,
    input  logic [PC_W-1:0]    ret_addr,
    output logic [PC_W-1:0]    fetch_addr,
    output logic [LO_W-1:0]    lo_rd,
    output logic [LATCH_W-1:0] latch_rd
);

    pc_src_e            src;
    logic [PC_W-1:0]    pc_q;
    logic [PC_W-1:0]    pc_d;
    logic [LATCH_W-1:0] latch_q;

    pcu_select u_select (
        .ret_en   (ret_en),
        .jmp_en   (jmp_en),
        .lo_wr_en (lo_wr_en),
        .step_en  (step_en),
        .src      (src)
    );

    pcu_latch #(.W(LATCH_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (latch_wr_en),
        .wr_data (latch_wr_data),
        .q       (latch_q)
    );

    pcu_next #(.PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W)) u_next (
        .src      (src),
        .pc_q     (pc_q),
        .latch_q  (latch_q),
        .lo_data  (lo_wr_data),
        .jmp_imm  (jmp_imm),
        .ret_addr (ret_addr),
        .pc_d     (pc_d)
    );

    // Counter register: cleared on reset, loaded every cycle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // Present the counter and the readback views.
    assign fetch_addr = pc_q;
    assign lo_rd      = pc_q[LO_W-1:0];
    assign latch_rd   = latch_q;

    // R2: a lone step advances the whole counter by one, with wrap.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !lo_wr_en && !jmp_en && !ret_en)
        |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(1)));

    // R3/R9: a low-byte write takes the pre-edge latch, with no carry.
    p_low_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_en && !jmp_en && !ret_en)
        |=> fetch_addr == {$past(latch_rd), $past(lo_wr_data)});

    // R4: a jump loads the immediate below the top latch bits.
    p_jump_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_en && !ret_en)
        |=> fetch_addr[JMP_W-1:0] == $past(jmp_imm));

    // R5/R8: a return load wins over every other source.
    p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |=> fetch_addr == $past(ret_addr));

    // R8: with no source asserted, the counter holds.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !lo_wr_en && !jmp_en && !ret_en)
        |=> $stable(fetch_addr));

endmodule

// File: tb/pcu_paged_pc_test.sv
`timescale 1ns/1ps
module pcu_paged_pc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0, lo_wr_en = 1'b0, latch_wr_en = 1'b0;
    logic        jmp_en = 1'b0, ret_en = 1'b0;
    logic [7:0]  lo_wr_data = '0;
    logic [4:0]  latch_wr_data = '0;
    logic [10:0] jmp_imm = '0;
    logic [12:0] ret_addr = '0;
    logic [12:0] fetch_addr;
    logic [7:0]  lo_rd;
    logic [4:0]  latch_rd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pcu_paged_pc uut (
        .clk (clk), .rst_n (rst_n), .step_en (step_en),
        .lo_wr_en (lo_wr_en), .lo_wr_data (lo_wr_data),
        .latch_wr_en (latch_wr_en), .latch_wr_data (latch_wr_data),
        .jmp_en (jmp_en), .jmp_imm (jmp_imm),
        .ret_en (ret_en), .ret_addr (ret_addr),
        .fetch_addr (fetch_addr), .lo_rd (lo_rd), .latch_rd (latch_rd)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic        ret, jmp, lo, step, lw;
        logic [12:0] ret_a;
        logic [10:0] imm;
        logic [7:0]  lo_d;
        logic [4:0]  lat_d;
        logic [12:0] exp_pc;
        logic [4:0]  exp_lat;
    } vec_t;

    localparam int NV = 18;
    // Each row is applied for one cycle, in order, starting from reset.
    localparam vec_t [0:NV-1] VECS = '{
        '{"R2", 0,0,0,1,0, 13'h0,   11'h0,   8'h00, 5'h00, 13'h0001, 5'h00},
        '{"R2", 0,0,0,1,0, 13'h0,   11'h0,   8'h00, 5'h00, 13'h0002, 5'h00},
        '{"R6", 0,0,0,1,1, 13'h0,   11'h0,   8'h00, 5'h03, 13'h0003, 5'h03},
        '{"R3", 0,0,1,0,0, 13'h0,   11'h0,   8'h80, 5'h00, 13'h0380, 5'h03},
        '{"R2", 0,0,0,1,0, 13'h0,   11'h0,   8'h00, 5'h00, 13'h0381, 5'h03},
        '{"R3", 0,0,1,0,0, 13'h0,   11'h0,   8'hFF, 5'h00, 13'h03FF, 5'h03},
        '{"R2", 0,0,0,1,0, 13'h0,   11'h0,   8'h00, 5'h00, 13'h0400, 5'h03},
        '{"R3", 0,0,1,0,0, 13'h0,   11'h0,   8'h05, 5'h00, 13'h0305, 5'h03},
        '{"R6", 0,0,0,0,1, 13'h0,   11'h0,   8'h00, 5'h1E, 13'h0305, 5'h1E},
        '{"R4", 0,1,0,0,0, 13'h0,   11'h7AB, 8'h00, 5'h00, 13'h1FAB, 5'h1E},
        '{"R5", 1,0,0,0,0, 13'h123, 11'h0,   8'h00, 5'h00, 13'h0123, 5'h1E},
        '{"R8", 1,1,1,1,0, 13'h456, 11'h3C3, 8'h99, 5'h00, 13'h0456, 5'h1E},
        '{"R8", 0,1,1,1,0, 13'h0,   11'h001, 8'h99, 5'h00, 13'h1801, 5'h1E},
        '{"R8", 0,0,1,1,0, 13'h0,   11'h0,   8'h10, 5'h00, 13'h1E10, 5'h1E},
        '{"R8", 0,0,0,0,0, 13'h0,   11'h0,   8'h00, 5'h00, 13'h1E10, 5'h1E},
        '{"R9", 0,0,1,0,1, 13'h0,   11'h0,   8'h20, 5'h0A, 13'h1E20, 5'h0A},
        '{"R4", 0,1,0,0,0, 13'h0,   11'h7FF, 8'h00, 5'h00, 13'h0FFF, 5'h0A},
        '{"R3", 0,0,1,0,0, 13'h0,   11'h0,   8'h44, 5'h00, 13'h0A44, 5'h0A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        ret_en = v.ret; jmp_en = v.jmp; lo_wr_en = v.lo; step_en = v.step;
        latch_wr_en = v.lw; ret_addr = v.ret_a; jmp_imm = v.imm;
        lo_wr_data = v.lo_d; latch_wr_data = v.lat_d;
    endtask

    task automatic idle();
        ret_en = 0; jmp_en = 0; lo_wr_en = 0; step_en = 0; latch_wr_en = 0;
    endtask

    // One cycle: inputs are set at the falling edge, and outputs are read
    // at the next falling edge, after one rising edge.
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R7 is checked after every cycle: the readback always matches the counter.
    task automatic chk_all(input string req, input logic [12:0] pc, input logic [4:0] lat);
        chk(req, 32'(fetch_addr), 32'(pc));
        chk("R7", 32'(lo_rd), 32'(pc[7:0]));
        chk("R6", 32'(latch_rd), 32'(lat));
    endtask

    initial begin
        @(negedge clk);
        cycle();
        chk_all("R1", 13'h0000, 5'h00);   // R1: state after reset
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            cycle();
            chk_all(string'(VECS[i].tag), VECS[i].exp_pc, VECS[i].exp_lat);
        end
        // R6: the latch is 1F while the counter page stays 0A.
        idle(); latch_wr_en = 1; latch_wr_data = 5'h1F;
        cycle(); chk_all("R6", 13'h0A44, 5'h1F);
        // R3: top of memory, reached by a low-byte write.
        idle(); lo_wr_en = 1; lo_wr_data = 8'hFF;
        cycle(); chk_all("R3", 13'h1FFF, 5'h1F);
        // R2: wrap from 0x1FFF to 0x0000.
        idle(); step_en = 1;
        cycle(); chk_all("R2", 13'h0000, 5'h1F);
        // R1: a mid-run reset wins over the other loads.
        idle(); latch_wr_en = 1; latch_wr_data = 5'h07; step_en = 1;
        cycle(); chk_all("R6", 13'h0001, 5'h07);
        rst_n = 0; lo_wr_en = 1; lo_wr_data = 8'h55; jmp_en = 1; jmp_imm = 11'h123;
        cycle(); chk_all("R1", 13'h0000, 5'h00);
        idle(); rst_n = 1;
        cycle(); chk_all("R8", 13'h0000, 5'h00);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule